// File: doc/BRIEF.md
# Page ECC Error Report Collector

This block sits behind a packet-wise ECC decoder in a flash page read path. As each packet of a page is decoded, the decoder presents one result strobe with the number of bits it corrected, a flag that says whether decoding succeeded, and the index of the packet within the page. The block folds these results into one 32-bit report word, which software or a sequencer reads once the page is complete. The word has a fixed layout because a downstream reader decodes it.

The first packet of a page, index 0, is reported on its own in the low byte. Every later packet is merged into the second byte. That byte keeps the worst corrected count seen so far and the logical AND of the success flags. A separate transfer status word flags a page that the read path found to be erased, so that the reader knows to disregard the report.

A page begins with a start pulse that carries the number of packet results to expect. After that many results have been taken, the report freezes and a one-cycle done pulse is raised.

Top module: `ecc_page_report`

## Requirements
- R1: After reset, and in the cycle after a page start, the report word is 0x0000_8000 (bit 15 set, all other bits 0), the transfer status is 0 and done is low.
- R2: A taken result with index 0 writes its corrected count into report bits 5:0 and its success flag into bit 7 (1 = decoded). Bit 6 stays 0.
- R3: Taken results with a nonzero index update report bits 13:8 to the largest count seen among them in this page, not their sum.
- R4: Report bit 15 is the AND of the success flags of all nonzero-index results in this page. Once it is 0 it stays 0 until the next page start.
- R5: An incoming count above 63 is recorded as 63 in either count field.
- R6: A page-erased pulse while a page is in progress sets transfer status bit 16. All other status bits are always 0.
- R7: Done goes high for exactly one cycle, and it rises at the same clock edge that registers the last expected result. From then on, the report and status hold, and further results and erased pulses are ignored until the next page start.
- R8: A page start that expects 0 results raises done at the next edge, and the report keeps its cleared value.
- R9: A page start and a result in the same cycle: the start wins and the result is dropped.
- R10: Results and erased pulses that arrive before any page start has been issued are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| page_start | input | 1 | Begins a new page and clears the report |
| page_pkts | input | NPKT_W | Number of results expected, sampled with page_start |
| res_valid | input | 1 | Result strobe from the decoder |
| res_idx | input | IDX_W | Packet index of the result |
| res_count | input | CNT_IN_W | Corrected-bit count of the result |
| res_ok | input | 1 | 1 when the packet decoded successfully |
| page_erased | input | 1 | Page was detected as erased |
| err_report | output | 32 | Report word |
| xfer_status | output | 32 | Transfer status word (bit 16 = erased) |
| done | output | 1 | One-cycle pulse when the page's results are complete |

## Verification
Every result, start and erased pulse is registered at one clock edge, so its effect on err_report, xfer_status and done is visible right after that edge, with no further latency. The bench drives inputs on the falling edge and holds them for one cycle. It then samples on the next falling edge, which falls half a period after the edge that registered them. For the one-cycle done pulse, the bench checks the cycle just after the last result and then the cycle after that. This pins down both when the pulse rises and that it lasts only one cycle.

// File: rtl/ecc_report_pkg.sv
package ecc_report_pkg;

    localparam int REP_W       = 32;
    localparam int CNT_W       = 6;
    localparam int CNT_MAX     = (1 << CNT_W) - 1;
    localparam int P0_CNT_LSB  = 0;
    localparam int P0_OK_BIT   = 7;
    localparam int PN_CNT_LSB  = 8;
    localparam int PN_OK_BIT   = 15;
    localparam int ERASED_BIT  = 16;

    typedef struct packed {
        logic [CNT_W-1:0] p0_cnt;
        logic             p0_ok;
        logic [CNT_W-1:0] pn_cnt;
        logic             pn_ok;
    } report_t;

    localparam report_t REPORT_CLEAR = '{p0_cnt: '0, p0_ok: 1'b0, pn_cnt: '0, pn_ok: 1'b1};

    function automatic logic [REP_W-1:0] to_word(input report_t r);
        logic [REP_W-1:0] w;
        w = '0;
        w[P0_CNT_LSB +: CNT_W] = r.p0_cnt;
        w[P0_OK_BIT]           = r.p0_ok;
        w[PN_CNT_LSB +: CNT_W] = r.pn_cnt;
        w[PN_OK_BIT]           = r.pn_ok;
        return w;
    endfunction

endpackage

// File: rtl/ecc_cnt_sat.sv
module ecc_cnt_sat
    import ecc_report_pkg::*;
#(
    parameter int IN_W = 8
) (
    input  logic [IN_W-1:0]  cnt_i,
    output logic [CNT_W-1:0] cnt_o
);

    generate
        if (IN_W > CNT_W) begin : g_clip
            always_comb begin
                if (cnt_i > IN_W'(CNT_MAX)) begin
                    cnt_o = CNT_W'(CNT_MAX);
                end else begin
                    cnt_o = cnt_i[CNT_W-1:0];
                end
            end
        end else begin : g_pass
            always_comb begin
                cnt_o = CNT_W'(cnt_i);
            end
        end
    endgenerate

endmodule

// File: rtl/ecc_pkt_merge.sv
module ecc_pkt_merge
    import ecc_report_pkg::*;
(
    input  report_t          cur_i,
    input  logic             take_i,
    input  logic             first_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             ok_i,
    output report_t          nxt_o
);

    always_comb begin
        nxt_o = cur_i;
        if (take_i) begin
            if (first_i) begin
                nxt_o.p0_cnt = cnt_i;
                nxt_o.p0_ok  = ok_i;
            end else begin
                if (cnt_i > cur_i.pn_cnt) begin
                    nxt_o.pn_cnt = cnt_i;
                end
                nxt_o.pn_ok = cur_i.pn_ok & ok_i;
            end
        end
    end

endmodule

// File: rtl/ecc_pkt_tracker.sv
module ecc_pkt_tracker #(
    parameter int NPKT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [NPKT_W-1:0] total_i,
    input  logic              valid_i,
    output logic              take_o,
    output logic              busy_o,
    output logic              done_o
);

    typedef struct packed {
        logic              busy;
        logic              done;
        logic [NPKT_W-1:0] seen;
        logic [NPKT_W-1:0] total;
    } trk_t;

    trk_t trk_d, trk_q;
    logic [NPKT_W-1:0] seen_inc;

    assign take_o   = trk_q.busy & valid_i & ~start_i;
    assign seen_inc = trk_q.seen + NPKT_W'(1);

    always_comb begin
        trk_d      = trk_q;
        trk_d.done = 1'b0;
        if (start_i) begin
            trk_d.seen  = '0;
            trk_d.total = total_i;
            trk_d.busy  = (total_i != '0);
            trk_d.done  = (total_i == '0);
        end else if (take_o) begin
            trk_d.seen = seen_inc;
            if (seen_inc == trk_q.total) begin
                trk_d.busy = 1'b0;
                trk_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign busy_o = trk_q.busy;
    assign done_o = trk_q.done;

endmodule

// File: rtl/ecc_page_report.sv
module ecc_page_report
    import ecc_report_pkg::*;
#(
    parameter int CNT_IN_W = 8,
    parameter int IDX_W    = 4,
    parameter int NPKT_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              page_start,
    input  logic [NPKT_W-1:0] page_pkts,
    input  logic              res_valid,
    input  logic [IDX_W-1:0]  res_idx,
    input  logic [CNT_IN_W-1:0] res_count,
    input  logic              res_ok,
    input  logic              page_erased,
    output logic [REP_W-1:0]  err_report,
    output logic [REP_W-1:0]  xfer_status,
    output logic              done
);

    typedef struct packed {
        report_t rep;
        logic    erased;
    } state_t;

    state_t st_d, st_q;

    logic             take;
    logic             busy;
    logic [CNT_W-1:0] sat_cnt;
    report_t          merged;

    ecc_pkt_tracker #(.NPKT_W(NPKT_W)) u_trk (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (page_start),
        .total_i (page_pkts),
        .valid_i (res_valid),
        .take_o  (take),
        .busy_o  (busy),
        .done_o  (done)
    );

    ecc_cnt_sat #(.IN_W(CNT_IN_W)) u_sat (
        .cnt_i (res_count),
        .cnt_o (sat_cnt)
    );

    ecc_pkt_merge u_merge (
        .cur_i   (st_q.rep),
        .take_i  (take),
        .first_i (res_idx == '0),
        .cnt_i   (sat_cnt),
        .ok_i    (res_ok),
        .nxt_o   (merged)
    );

    always_comb begin
        st_d = st_q;
        if (page_start) begin
            st_d.rep    = REPORT_CLEAR;
            st_d.erased = 1'b0;
        end else begin
            st_d.rep = merged;
            if (busy && page_erased) begin
                st_d.erased = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.rep    <= REPORT_CLEAR;
            st_q.erased <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        err_report             = to_word(st_q.rep);
        xfer_status            = '0;
        xfer_status[ERASED_BIT] = st_q.erased;
    end

endmodule

// File: rtl/ecc_page_report_chk.sv
module ecc_page_report_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        page_start,
    input logic        page_erased,
    input logic        busy,
    input logic [31:0] err_report,
    input logic [31:0] xfer_status,
    input logic        done
);

    assert_start_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        page_start |=> (err_report == 32'h0000_8000) && (xfer_status == 32'h0));

    assert_later_max_grows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !page_start |=> err_report[13:8] >= $past(err_report[13:8]));

    assert_ok_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!page_start && !err_report[15]) |=> !err_report[15]);

    assert_erased_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && page_erased && !page_start) |=> xfer_status[16]);

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !page_start) |=> !done);

    assert_frozen_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !page_start) |=> $stable(err_report) && $stable(xfer_status));

endmodule

bind ecc_page_report ecc_page_report_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .page_start  (page_start),
    .page_erased (page_erased),
    .busy        (busy),
    .err_report  (err_report),
    .xfer_status (xfer_status),
    .done        (done)
);

// File: tb/tb_ecc_page_report.sv
module tb_ecc_page_report;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        page_start = 1'b0;
    logic [4:0]  page_pkts = '0;
    logic        res_valid = 1'b0;
    logic [3:0]  res_idx = '0;
    logic [7:0]  res_count = '0;
    logic        res_ok = 1'b0;
    logic        page_erased = 1'b0;
    logic [31:0] err_report;
    logic [31:0] xfer_status;
    logic        done;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    ecc_page_report dut (
        .clk(clk), .rst_n(rst_n), .page_start(page_start), .page_pkts(page_pkts),
        .res_valid(res_valid), .res_idx(res_idx), .res_count(res_count), .res_ok(res_ok),
        .page_erased(page_erased), .err_report(err_report), .xfer_status(xfer_status),
        .done(done)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic start_page(input int n);
        @(negedge clk);
        page_start = 1'b1;
        page_pkts  = 5'(n);
        @(negedge clk);
        page_start = 1'b0;
    endtask

    task automatic send(input int idx, input int cnt, input bit ok);
        @(negedge clk);
        res_valid = 1'b1;
        res_idx   = 4'(idx);
        res_count = 8'(cnt);
        res_ok    = ok;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    task automatic pulse_erased();
        @(negedge clk);
        page_erased = 1'b1;
        @(negedge clk);
        page_erased = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 reset report", err_report, 32'h0000_8000);
        check("R1 reset status", xfer_status, 32'h0);
        check("R1 reset done", {31'b0, done}, 32'h0);
    endtask

    task automatic t_idle_ignored();
        send(0, 9, 1'b1);
        send(2, 20, 1'b0);
        pulse_erased();
        check("R10 idle report", err_report, 32'h0000_8000);
        check("R10 idle status", xfer_status, 32'h0);
        check("R10 idle done", {31'b0, done}, 32'h0);
    endtask

    task automatic t_basic();
        start_page(4);
        check("R1 start report", err_report, 32'h0000_8000);
        send(0, 3, 1'b1);
        check("R2 first packet", err_report, 32'h0000_8083);
        send(1, 5, 1'b1);
        send(2, 2, 1'b1);
        check("R3 max not sum", err_report, 32'h0000_8583);
        check("R7 no early done", {31'b0, done}, 32'h0);
        send(3, 7, 1'b1);
        check("R3 final max", err_report, 32'h0000_8783);
        check("R7 done rises", {31'b0, done}, 32'h1);
        @(negedge clk);
        check("R7 done one cycle", {31'b0, done}, 32'h0);
        send(1, 30, 1'b0);
        pulse_erased();
        check("R7 frozen report", err_report, 32'h0000_8783);
        check("R7 frozen status", xfer_status, 32'h0);
    endtask

    task automatic t_failures();
        start_page(3);
        send(0, 1, 1'b0);
        check("R2 first fail bit7 clear", err_report, 32'h0000_8001);
        send(1, 4, 1'b0);
        check("R4 later fail", err_report, 32'h0000_0401);
        send(2, 2, 1'b1);
        check("R4 fail sticky", err_report, 32'h0000_0401);
        check("R7 done", {31'b0, done}, 32'h1);
    endtask

    task automatic t_saturate();
        start_page(2);
        send(0, 200, 1'b1);
        send(1, 100, 1'b1);
        check("R5 saturate", err_report, 32'h0000_BFBF);
    endtask

    task automatic t_erased();
        start_page(2);
        pulse_erased();
        check("R6 erased flag", xfer_status, 32'h0001_0000);
        send(0, 0, 1'b1);
        send(1, 0, 1'b1);
        check("R6 erased held", xfer_status, 32'h0001_0000);
        start_page(1);
        check("R1 start clears status", xfer_status, 32'h0);
        send(0, 0, 1'b1);
    endtask

    task automatic t_zero_pkts();
        start_page(0);
        check("R8 zero done", {31'b0, done}, 32'h1);
        check("R8 zero report", err_report, 32'h0000_8000);
        @(negedge clk);
        check("R8 zero done drops", {31'b0, done}, 32'h0);
    endtask

    task automatic t_start_wins();
        @(negedge clk);
        page_start = 1'b1;
        page_pkts  = 5'd2;
        res_valid  = 1'b1;
        res_idx    = 4'd0;
        res_count  = 8'd9;
        res_ok     = 1'b1;
        @(negedge clk);
        page_start = 1'b0;
        res_valid  = 1'b0;
        check("R9 start wins", err_report, 32'h0000_8000);
        send(0, 4, 1'b1);
        check("R9 not counted", {31'b0, done}, 32'h0);
        send(1, 6, 1'b1);
        check("R9 done after two", {31'b0, done}, 32'h1);
        check("R9 report", err_report, 32'h0000_8684);
    endtask

    task automatic t_out_of_order();
        start_page(3);
        send(2, 5, 1'b1);
        send(1, 6, 1'b1);
        send(0, 2, 1'b1);
        check("R2 idx0 last", err_report, 32'h0000_8682);
        check("R7 done ooo", {31'b0, done}, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_ignored();
        t_basic();
        t_failures();
        t_saturate();
        t_erased();
        t_zero_pkts();
        t_start_wins();
        t_out_of_order();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule